// File: doc/BRIEF.md
# Mode-Banked Segment Address Translator

This block sits on the path from a processor to memory. It converts a 16-bit virtual address into an 18-bit physical address using eight segment entries per address space. Each entry holds a base address and a descriptor, and the descriptor carries a length and an access right. The block keeps two complete sets of entries, one for kernel mode and one for user mode. A mode bit held inside the block picks the set used for each translation. Translation is combinational, from the request inputs to the physical address and fault outputs.

After reset the block is in kernel mode with translation off, so every virtual address passes through unchanged. Kernel software loads the entries over a small register-write port, sets the enable bit, and can then drop to user mode. Once in user mode, every register write is refused and flagged. When an access breaks a segment's length or access right, the block raises a fault and holds the memory request low.

Top module: `seg_xlate_unit`

## Requirements
- R1: After a synchronous reset the block is in kernel mode (`cur_user`=0), translation is off (`xlate_on`=0), and every entry in both sets is cleared to base 0, length 0, no access.
- R2: While translation is off, `mem_paddr` equals `cpu_vaddr` zero-extended to 18 bits, no fault is raised, and `mem_req_valid` follows `cpu_req_valid`.
- R3: While translation is on, the kernel set (bank 0) translates when `cur_user`=0 and the user set (bank 1) translates when `cur_user`=1.
- R4: `cpu_vaddr[15:13]` selects the segment and `cpu_vaddr[12:0]` is the offset. The physical address is (base << 6) + offset, truncated to 18 bits, where base is the segment's 12-bit base value.
- R5: The descriptor length field is `reg_wdata[6:0]`, counted in 64-byte blocks. A valid access whose `offset[12:6]` is greater than the length raises `fault_len`.
- R6: The descriptor access field is `reg_wdata[8:7]`: 00 = no access, 01 = read-only, 10 = no access, 11 = read/write. A valid access to a no-access segment, or a write (`cpu_write`=1) to a read-only segment, raises `fault_acc`.
- R7: `mem_req_valid` is low whenever either fault is high. Faults are raised only while `cpu_req_valid`=1.
- R8: Register map, written on the clock edge after `reg_wr_en`=1 in kernel mode. When `reg_addr[5]`=1 the write goes to the control register: `reg_wdata[0]` is the enable bit and `reg_wdata[1]` is the user-mode bit. Otherwise `reg_addr[4]` selects the bank (0 = kernel, 1 = user), `reg_addr[3]` selects the register (0 = base from `reg_wdata[11:0]`, 1 = descriptor), and `reg_addr[2:0]` selects the segment.
- R9: In user mode a register write changes no state, and `priv_fault` is high in the same cycle that `reg_wr_en` is high. `priv_fault` is low for every write made in kernel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor access request |
| cpu_vaddr | input | 16 | Virtual address |
| cpu_write | input | 1 | 1 = store, 0 = load or fetch |
| mem_req_valid | output | 1 | Request forwarded to memory |
| mem_paddr | output | 18 | Physical address |
| fault_len | output | 1 | Offset beyond segment length |
| fault_acc | output | 1 | Access right violated |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register select |
| reg_wdata | input | 12 | Register write data |
| priv_fault | output | 1 | Register write attempted in user mode |
| cur_user | output | 1 | Current mode, 1 = user |
| xlate_on | output | 1 | Translation enable state |

## Verification
The bench builds the block with its default parameters: 16-bit virtual and 18-bit physical addresses, 3 segment bits and 64-byte blocks. These values put every corner within a few accesses. A base of 0xFFF wraps the sum past 2^18. A length of 10 separates block 10 from block 11. Length 127 covers the full 8 KB segment. With only two banks, each bank's entries can be loaded from kernel mode and then shown to be out of reach from user mode.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_RO   = 2'b01,
    ACC_RSV  = 2'b10,
    ACC_RW   = 2'b11
  } acc_t;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_USER_BIT = 1;
endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int N_SEG  = 8,
  parameter int BASE_W = 12,
  parameter int LEN_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_desc,
  input  logic [$clog2(N_SEG)-1:0] wr_idx,
  input  logic [BASE_W-1:0]        wr_data,
  input  logic [$clog2(N_SEG)-1:0] rd_idx,
  output logic [BASE_W-1:0]        rd_base,
  output logic [LEN_W-1:0]         rd_len,
  output seg_pkg::acc_t            rd_acc
);
  logic [BASE_W-1:0] base_q [N_SEG];
  logic [LEN_W-1:0]  len_q  [N_SEG];
  seg_pkg::acc_t     acc_q  [N_SEG];

  for (genvar i = 0; i < N_SEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        acc_q[i]  <= seg_pkg::ACC_NONE;
      end else if (wr_en && wr_idx == i) begin
        if (wr_desc) begin
          len_q[i] <= wr_data[LEN_W-1:0];
          acc_q[i] <= seg_pkg::acc_t'(wr_data[LEN_W+1:LEN_W]);
        end else begin
          base_q[i] <= wr_data;
        end
      end
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_len  = len_q[rd_idx];
  assign rd_acc  = acc_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 18,
  parameter int SEG_W  = 3,
  parameter int BLK_SH = 6,
  localparam int OFF_W  = VA_W - SEG_W,
  localparam int BASE_W = PA_W - BLK_SH,
  localparam int LEN_W  = OFF_W - BLK_SH
) (
  input  logic              en,
  input  logic              valid,
  input  logic              write,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [BASE_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  seg_pkg::acc_t     acc,
  output logic [PA_W-1:0]   paddr,
  output logic              f_len,
  output logic              f_acc,
  output logic              mem_valid
);
  logic [OFF_W-1:0] offset;
  logic [LEN_W-1:0] blk;
  logic             can_rd, can_wr;

  assign offset = vaddr[OFF_W-1:0];
  assign blk    = offset[OFF_W-1:BLK_SH];
  assign can_rd = (acc == seg_pkg::ACC_RO) || (acc == seg_pkg::ACC_RW);
  assign can_wr = (acc == seg_pkg::ACC_RW);

  always_comb begin
    if (en) begin
      paddr = {base, {BLK_SH{1'b0}}} + PA_W'(offset);
      f_len = valid && (blk > len);
      f_acc = valid && (write ? !can_wr : !can_rd);
    end else begin
      paddr = PA_W'(vaddr);
      f_len = 1'b0;
      f_acc = 1'b0;
    end
    mem_valid = valid && !f_len && !f_acc;
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit #(
  parameter int VA_W   = 16,
  parameter int PA_W   = 18,
  parameter int SEG_W  = 3,
  parameter int BLK_SH = 6,
  localparam int N_SEG  = 1 << SEG_W,
  localparam int OFF_W  = VA_W - SEG_W,
  localparam int BASE_W = PA_W - BLK_SH,
  localparam int LEN_W  = OFF_W - BLK_SH,
  localparam int RA_W   = SEG_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic [VA_W-1:0]   cpu_vaddr,
  input  logic              cpu_write,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_paddr,
  output logic              fault_len,
  output logic              fault_acc,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [BASE_W-1:0] reg_wdata,
  output logic              priv_fault,
  output logic              cur_user,
  output logic              xlate_on
);
  logic              user_q, en_q;
  logic              wr_ok, wr_ctrl;
  logic [SEG_W-1:0]  seg_sel;
  logic [BASE_W-1:0] b_base [2];
  logic [LEN_W-1:0]  b_len  [2];
  seg_pkg::acc_t     b_acc  [2];

  assign wr_ok   = reg_wr_en && !user_q;
  assign wr_ctrl = reg_addr[RA_W-1];
  assign seg_sel = cpu_vaddr[VA_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      user_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_ok && wr_ctrl) begin
      en_q   <= reg_wdata[seg_pkg::CTRL_EN_BIT];
      user_q <= reg_wdata[seg_pkg::CTRL_USER_BIT];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    seg_bank #(.N_SEG(N_SEG), .BASE_W(BASE_W), .LEN_W(LEN_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_ok && !wr_ctrl && (reg_addr[SEG_W+1] == b[0])),
      .wr_desc (reg_addr[SEG_W]),
      .wr_idx  (reg_addr[SEG_W-1:0]),
      .wr_data (reg_wdata),
      .rd_idx  (seg_sel),
      .rd_base (b_base[b]),
      .rd_len  (b_len[b]),
      .rd_acc  (b_acc[b])
    );
  end

  seg_check #(.VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W), .BLK_SH(BLK_SH)) u_check (
    .en        (en_q),
    .valid     (cpu_req_valid),
    .write     (cpu_write),
    .vaddr     (cpu_vaddr),
    .base      (b_base[user_q]),
    .len       (b_len[user_q]),
    .acc       (b_acc[user_q]),
    .paddr     (mem_paddr),
    .f_len     (fault_len),
    .f_acc     (fault_acc),
    .mem_valid (mem_req_valid)
  );

  assign priv_fault = reg_wr_en && user_q;
  assign cur_user   = user_q;
  assign xlate_on   = en_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpu_req_valid,
  input logic [15:0] cpu_vaddr,
  input logic        mem_req_valid,
  input logic [17:0] mem_paddr,
  input logic        fault_len,
  input logic        fault_acc,
  input logic        reg_wr_en,
  input logic [5:0]  reg_addr,
  input logic [11:0] reg_wdata,
  input logic        priv_fault,
  input logic        cur_user,
  input logic        xlate_on
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!cur_user && !xlate_on));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !xlate_on |-> (mem_paddr == {2'b00, cpu_vaddr} && mem_req_valid == cpu_req_valid));

  // R7
  fault_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_len || fault_acc) |-> (!mem_req_valid && cpu_req_valid));

  // R8
  ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !cur_user && reg_addr[5]) |=>
      (xlate_on == $past(reg_wdata[0]) && cur_user == $past(reg_wdata[1])));

  // R9
  user_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && cur_user) |=> (cur_user && $stable(xlate_on)));

  // R9
  priv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> (priv_fault == cur_user));
endmodule

bind seg_xlate_unit seg_xlate_chk u_chk (
  .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_vaddr(cpu_vaddr),
  .mem_req_valid(mem_req_valid), .mem_paddr(mem_paddr), .fault_len(fault_len),
  .fault_acc(fault_acc), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .priv_fault(priv_fault), .cur_user(cur_user),
  .xlate_on(xlate_on)
);

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req_valid = 1'b0;
  logic [15:0] cpu_vaddr = '0;
  logic        cpu_write = 1'b0;
  logic        mem_req_valid;
  logic [17:0] mem_paddr;
  logic        fault_len, fault_acc;
  logic        reg_wr_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [11:0] reg_wdata = '0;
  logic        priv_fault, cur_user, xlate_on;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [11:0] d, output logic pf);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    #1 pf = priv_fault;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic acc(input logic [15:0] va, input logic wr, input logic v);
    @(negedge clk);
    cpu_vaddr = va; cpu_write = wr; cpu_req_valid = v;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 mode", cur_user, 0);
    chk("R1 enable", xlate_on, 0);
    chk("R1 priv", priv_fault, 0);
  endtask

  task automatic t_passthru;
    acc(16'hFFFF, 1'b1, 1'b1);
    chk("R2 paddr", mem_paddr, 18'h0FFFF);
    chk("R2 valid", mem_req_valid, 1);
    chk("R2 faults", {fault_len, fault_acc}, 0);
    acc(16'h1234, 1'b0, 1'b0);
    chk("R2 valid low", mem_req_valid, 0);
  endtask

  task automatic t_kernel;
    logic pf;
    wreg(6'd0, 12'h100, pf);            // kernel seg0 base
    chk("R9 kernel no priv", pf, 0);
    wreg(6'd8, 12'h1FF, pf);            // seg0 RW len 127
    wreg(6'd7, 12'hFFF, pf);            // seg7 base
    wreg(6'd15, 12'h08A, pf);           // seg7 RO len 10
    wreg(6'd10, 12'h005, pf);           // seg2 none len 5
    wreg(6'd16, 12'h200, pf);           // user seg0 base
    wreg(6'd24, 12'h1FF, pf);           // user seg0 RW
    acc(16'h0123, 1'b0, 1'b1);
    chk("R8 not enabled yet", mem_paddr, 18'h00123);
    wreg(6'h20, 12'h001, pf);
    chk("R8 enable", xlate_on, 1);
    chk("R8 still kernel", cur_user, 0);
    acc(16'h0123, 1'b1, 1'b1);
    chk("R4 seg0", mem_paddr, 18'h04123);
    chk("R3 kernel bank valid", mem_req_valid, 1);
    acc(16'h1FFF, 1'b1, 1'b1);
    chk("R5 max len no fault", fault_len, 0);
    chk("R4 seg0 top", mem_paddr, 18'h05FFF);
    acc(16'hE040, 1'b0, 1'b1);
    chk("R4 wrap", mem_paddr, 18'h00000);
    chk("R6 RO read ok", fault_acc, 0);
    acc(16'hE280, 1'b0, 1'b1);
    chk("R5 block == len", fault_len, 0);
    acc(16'hE2C0, 1'b0, 1'b1);
    chk("R5 block > len", fault_len, 1);
    chk("R7 blocked len", mem_req_valid, 0);
    acc(16'hE2C0, 1'b0, 1'b0);
    chk("R7 no fault w/o valid", fault_len, 0);
    acc(16'hE000, 1'b1, 1'b1);
    chk("R6 RO write", fault_acc, 1);
    chk("R7 blocked acc", mem_req_valid, 0);
    acc(16'h4000, 1'b0, 1'b1);
    chk("R6 none read", fault_acc, 1);
    acc(16'h6000, 1'b0, 1'b1);          // seg3 cleared at reset
    chk("R1 cleared entry", fault_acc, 1);
  endtask

  task automatic t_user;
    logic pf;
    wreg(6'h20, 12'h003, pf);
    chk("R8 to user", cur_user, 1);
    acc(16'h0010, 1'b1, 1'b1);
    chk("R3 user bank", mem_paddr, 18'h08010);
    chk("R3 user valid", mem_req_valid, 1);
    wreg(6'h20, 12'h000, pf);
    chk("R9 priv ctrl", pf, 1);
    chk("R9 mode kept", cur_user, 1);
    chk("R9 enable kept", xlate_on, 1);
    wreg(6'd16, 12'h001, pf);
    chk("R9 priv base", pf, 1);
    acc(16'h0010, 1'b0, 1'b1);
    chk("R9 base kept", mem_paddr, 18'h08010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    t_reset();
    t_passthru();
    t_kernel();
    t_user();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule